// File: doc/BRIEF.md
# Downstream Command Mailbox

This block gives software a small register window for sending one command at a time to a peripheral on a serial side-band link. Software fills the second and third header dwords and the data dword, then writes header dword 0. That last write carries the command kind, the target select, the first three header bytes and a start bit. When the start bit is set and no command is in flight, the block launches the command. The start bit then reads back as a busy flag. Hardware clears the flag when the link reports that the command has finished.

The block offers the command to the link layer on a valid/ready channel. The link layer returns a one-cycle done pulse. With that pulse come six error flags and, for a configuration read, a 32-bit result. On completion the block latches a completion flag and the reported error flags in a status register. Software clears each status flag by writing a one to its bit. An interrupt line is high whenever any status flag is set.

For configuration commands, header byte 0 holds address bits 15:8 and header byte 1 holds address bits 7:0. A configuration write takes its value from header dword 1. A configuration read returns its result in the same dword.

Top module: `dncmd_mailbox`

## Requirements
- R1: After reset, every register reads 0x0000_0000, `irq` is 0 and `link_req_valid` is 0.
- R2: While idle, a write updates the register at its offset, and reads return the stored value with reserved bits read as zero. The offsets are 0x00 header 0, 0x04 header 1, 0x08 header 2 and 0x0C data. Header 0 holds kind in bits 2:0, busy in bit 3, target in bits 5:4 and header bytes 0..2 in bits 15:8, 23:16 and 31:24, with bits 7:6 reserved. Header 2 keeps only bits 7:0, which hold header byte 7. An unmapped offset reads zero.
- R3: A write to header 0 with bit 3 set while idle launches a command: busy (header 0 bit 3) and `link_req_valid` read 1 one cycle later. A write with bit 3 clear only stores the fields.
- R4: `link_req_valid` stays high, and the command outputs stay unchanged, until a cycle with `link_req_ready` high. `link_hdata` byte k sits at bits 8k+7:8k. Bytes 0..2 come from header 0, bytes 3..6 from header 1 bits 7:0 upward, and byte 7 from header 2.
- R5: While busy, writes to all four mailbox dwords are ignored, and no second command is launched.
- R6: A `link_done` pulse after acceptance clears busy and sets status bit 28 in the same cycle. Error flags `link_err[0..5]` set status bits 0, 1, 2, 4, 5 and 6 in the same cycle.
- R7: On completion of a command of kind 1 (configuration read), header 1 takes the value on `link_rsp_data`. For any other kind, header 1 is unchanged. Kind 0 (configuration write) carries header 1 in `link_hdata` bytes 3..6.
- R8: A write to offset 0x70 clears each status bit written with one and keeps each bit written with zero. If a completion sets a bit in the same cycle that software clears it, the set wins.
- R9: `irq` is 1 exactly when the status register is non-zero.
- R10: A `link_done` pulse while idle, or while the request is still waiting to be accepted, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Register byte offset for reads and writes |
| host_wdata | input | 32 | Write data |
| host_rdata | output | 32 | Read data for `host_addr`, combinational |
| link_req_valid | output | 1 | Command offered to the link layer |
| link_req_ready | input | 1 | Link layer accepts the command |
| link_kind | output | 3 | Command kind |
| link_target | output | 2 | Target select |
| link_hdata | output | 64 | Header bytes 0..7 |
| link_wdata | output | 32 | Data dword |
| link_done | input | 1 | One-cycle completion pulse |
| link_err | input | 6 | Error flags valid with `link_done` |
| link_rsp_data | input | 32 | Configuration read result valid with `link_done` |
| irq | output | 1 | Any status bit set |

## Verification
A sequencer stuck busy or stuck idle shows up at once. The header 0 bit 3 read would disagree with `link_req_valid` in the cycle after the launch write or after the done pulse. A dropped guard lets a write made while busy change a register that is read back before the next command. An error flag sent to the wrong bit, or a clear that beats a same-cycle set, appears in the status read one cycle after the done pulse, and `irq` follows in that same cycle.

// File: rtl/dncmd_pkg.sv
`timescale 1ns/1ps
package dncmd_pkg;

  localparam int unsigned OFF_HDR0 = 32'h00;
  localparam int unsigned OFF_HDR1 = 32'h04;
  localparam int unsigned OFF_HDR2 = 32'h08;
  localparam int unsigned OFF_DATA = 32'h0C;
  localparam int unsigned OFF_STAT = 32'h70;

  localparam int unsigned BUSY_BIT = 3;
  localparam int unsigned ERR_BITS = 6;
  localparam int unsigned FLAG_CNT = ERR_BITS + 1;
  localparam int unsigned DONE_POS = 28;

  typedef enum logic [2:0] {
    CK_CFG_WR  = 3'd0,
    CK_CFG_RD  = 3'd1,
    CK_LINKRST = 3'd2,
    CK_PERIPH  = 3'd4,
    CK_VWIRE   = 3'd5,
    CK_OOB     = 3'd6,
    CK_FLASH   = 3'd7
  } cmd_kind_e;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_OFFER = 2'd1,
    SQ_WAIT  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [2:0]  kind;
    logic [1:0]  target;
    logic [23:0] hb012;
    logic [31:0] hdr1;
    logic [7:0]  hb7;
    logic [31:0] data;
  } mbx_fields_t;

  // status bit position of flag i (error flags first, completion last)
  function automatic int unsigned flag_pos(int unsigned i);
    case (i)
      0: return 0;
      1: return 1;
      2: return 2;
      3: return 4;
      4: return 5;
      5: return 6;
      default: return DONE_POS;
    endcase
  endfunction

endpackage

// File: rtl/mbx_regs.sv
`timescale 1ns/1ps
module mbx_regs
  import dncmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        busy,
  input  logic        we_h0,
  input  logic        we_h1,
  input  logic        we_h2,
  input  logic        we_dat,
  input  logic [31:0] wdata,
  input  logic        load_h1,
  input  logic [31:0] load_val,
  output mbx_fields_t fields
);

  mbx_fields_t f_q;
  logic unused_wbits;
  assign unused_wbits = ^{wdata[7:6], wdata[BUSY_BIT]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_q <= '0;
    end else begin
      if (we_h0) begin
        f_q.kind   <= wdata[2:0];
        f_q.target <= wdata[5:4];
        f_q.hb012  <= wdata[31:8];
      end
      if (load_h1)    f_q.hdr1 <= load_val;
      else if (we_h1) f_q.hdr1 <= wdata;
      if (we_h2)  f_q.hb7  <= wdata[7:0];
      if (we_dat) f_q.data <= wdata;
    end
  end

  assign fields = f_q;

  // R5
  hold_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(f_q.hb7) && $stable(f_q.data) && $stable(f_q.kind)));

endmodule

// File: rtl/mbx_seq.sv
`timescale 1ns/1ps
module mbx_seq
  import dncmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  logic link_req_ready,
  input  logic link_done,
  output logic busy,
  output logic link_req_valid,
  output logic done_evt
);

  seq_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= SQ_IDLE;
    end else begin
      case (st_q)
        SQ_IDLE:  if (launch)         st_q <= SQ_OFFER;
        SQ_OFFER: if (link_req_ready) st_q <= SQ_WAIT;
        SQ_WAIT:  if (link_done)      st_q <= SQ_IDLE;
        default:                      st_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy           = (st_q != SQ_IDLE);
  assign link_req_valid = (st_q == SQ_OFFER);
  assign done_evt       = (st_q == SQ_WAIT) && link_done;

  // R4
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_req_valid && !link_req_ready) |=> link_req_valid);

  // R6
  busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(link_done));

endmodule

// File: rtl/mbx_status.sv
`timescale 1ns/1ps
module mbx_status
  import dncmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr_we,
  input  logic [31:0]         clr_mask,
  input  logic                set_evt,
  input  logic [ERR_BITS-1:0] err_in,
  output logic [31:0]         status,
  output logic                irq
);

  logic [FLAG_CNT-1:0] flags_q;

  for (genvar i = 0; i < FLAG_CNT; i++) begin : g_flag
    localparam int unsigned POS = flag_pos(i);
    logic src;
    if (i == ERR_BITS) begin : g_done
      assign src = 1'b1;
    end else begin : g_err
      assign src = err_in[i];
    end
    always_ff @(posedge clk) begin
      if (!rst_n)                      flags_q[i] <= 1'b0;
      else if (set_evt && src)         flags_q[i] <= 1'b1;
      else if (clr_we && clr_mask[POS]) flags_q[i] <= 1'b0;
    end
  end

  always_comb begin
    status = '0;
    for (int unsigned i = 0; i < FLAG_CNT; i++) status[flag_pos(i)] = flags_q[i];
  end

  assign irq = |flags_q;

  // R6
  done_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> status[DONE_POS]);

  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_mask[DONE_POS] && !set_evt) |=> !status[DONE_POS]);

  // R9
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(set_evt));

endmodule

// File: rtl/dncmd_mailbox.sv
`timescale 1ns/1ps
module dncmd_mailbox
  import dncmd_pkg::*;
#(
  parameter int unsigned ADDR_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                host_we,
  input  logic [ADDR_W-1:0]   host_addr,
  input  logic [31:0]         host_wdata,
  output logic [31:0]         host_rdata,
  output logic                link_req_valid,
  input  logic                link_req_ready,
  output logic [2:0]          link_kind,
  output logic [1:0]          link_target,
  output logic [63:0]         link_hdata,
  output logic [31:0]         link_wdata,
  input  logic                link_done,
  input  logic [ERR_BITS-1:0] link_err,
  input  logic [31:0]         link_rsp_data,
  output logic                irq
);

  localparam logic [ADDR_W-1:0] A_H0 = ADDR_W'(OFF_HDR0);
  localparam logic [ADDR_W-1:0] A_H1 = ADDR_W'(OFF_HDR1);
  localparam logic [ADDR_W-1:0] A_H2 = ADDR_W'(OFF_HDR2);
  localparam logic [ADDR_W-1:0] A_DT = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(OFF_STAT);

  logic        busy, done_evt, launch, open_wr;
  mbx_fields_t fields;
  logic [31:0] status;

  assign open_wr = host_we && !busy;
  assign launch  = open_wr && (host_addr == A_H0) && host_wdata[BUSY_BIT];

  mbx_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .we_h0    (open_wr && (host_addr == A_H0)),
    .we_h1    (open_wr && (host_addr == A_H1)),
    .we_h2    (open_wr && (host_addr == A_H2)),
    .we_dat   (open_wr && (host_addr == A_DT)),
    .wdata    (host_wdata),
    .load_h1  (done_evt && (fields.kind == CK_CFG_RD)),
    .load_val (link_rsp_data),
    .fields   (fields)
  );

  mbx_seq u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .launch         (launch),
    .link_req_ready (link_req_ready),
    .link_done      (link_done),
    .busy           (busy),
    .link_req_valid (link_req_valid),
    .done_evt       (done_evt)
  );

  mbx_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_we   (host_we && (host_addr == A_ST)),
    .clr_mask (host_wdata),
    .set_evt  (done_evt),
    .err_in   (link_err),
    .status   (status),
    .irq      (irq)
  );

  always_comb begin
    case (host_addr)
      A_H0:    host_rdata = {fields.hb012, 2'b00, fields.target, busy, fields.kind};
      A_H1:    host_rdata = fields.hdr1;
      A_H2:    host_rdata = {24'h0, fields.hb7};
      A_DT:    host_rdata = fields.data;
      A_ST:    host_rdata = status;
      default: host_rdata = '0;
    endcase
  end

  assign link_kind   = fields.kind;
  assign link_target = fields.target;
  assign link_hdata  = {fields.hb7, fields.hdr1, fields.hb012};
  assign link_wdata  = fields.data;

  // R3
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (link_req_valid && (link_kind == $past(host_wdata[2:0]))));

  // R10
  stray_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_done && !busy) |=> $stable(status));

endmodule

// File: tb/dncmd_mailbox_test.sv
`timescale 1ns/1ps
module dncmd_mailbox_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        link_req_valid;
  logic        link_req_ready = 1'b0;
  logic [2:0]  link_kind;
  logic [1:0]  link_target;
  logic [63:0] link_hdata;
  logic [31:0] link_wdata;
  logic        link_done = 1'b0;
  logic [5:0]  link_err = '0;
  logic [31:0] link_rsp_data = '0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit timed_out = 0;

  always #2.5 clk = ~clk;

  dncmd_mailbox uut (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .link_req_valid(link_req_valid), .link_req_ready(link_req_ready),
    .link_kind(link_kind), .link_target(link_target), .link_hdata(link_hdata),
    .link_wdata(link_wdata), .link_done(link_done), .link_err(link_err),
    .link_rsp_data(link_rsp_data), .irq(irq)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    host_addr = a;
    #0.5;
    d = host_rdata;
  endtask

  task automatic accept();
    @(negedge clk); link_req_ready = 1'b1;
    @(negedge clk); link_req_ready = 1'b0;
  endtask

  task automatic finish_cmd(logic [5:0] e, logic [31:0] r);
    @(negedge clk); link_done = 1'b1; link_err = e; link_rsp_data = r;
    @(negedge clk); link_done = 1'b0; link_err = '0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    foreach (v[i]) ;
    rd(8'h00, v); chk("R1 hdr0", v, 0);
    rd(8'h04, v); chk("R1 hdr1", v, 0);
    rd(8'h0C, v); chk("R1 data", v, 0);
    rd(8'h70, v); chk("R1 status", v, 0);
    chk("R1 irq", irq, 0);
    chk("R1 valid", link_req_valid, 0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(8'h04, 32'hA5A5_1234);
    wr(8'h08, 32'hFFFF_FF3C);
    wr(8'h0C, 32'hDEAD_BEEF);
    wr(8'h00, 32'hC2B1_A0F5);
    rd(8'h04, v); chk("R2 hdr1", v, 32'hA5A5_1234);
    rd(8'h08, v); chk("R2 hdr2 reserved", v, 32'h0000_003C);
    rd(8'h0C, v); chk("R2 data", v, 32'hDEAD_BEEF);
    rd(8'h00, v); chk("R2 hdr0 reserved", v, 32'hC2B1_A035);
    rd(8'h40, v); chk("R2 unmapped", v, 0);
    chk("R3 no launch without start bit", link_req_valid, 0);
  endtask

  task automatic t_launch_hold_busy();
    logic [31:0] v;
    wr(8'h00, 32'hC2B1_A03D);
    chk("R3 valid after launch", link_req_valid, 1);
    rd(8'h00, v); chk("R3 busy bit", v, 32'hC2B1_A03D);
    chk("R4 kind", link_kind, 5);
    chk("R4 target", link_target, 3);
    chk("R4 hdata", link_hdata, 64'h3CA5_A512_34C2_B1A0);
    chk("R4 wdata", link_wdata, 32'hDEAD_BEEF);
    repeat (3) @(negedge clk);
    chk("R4 held without ready", link_req_valid, 1);
    wr(8'h00, 32'h0000_0009);
    wr(8'h0C, 32'h1111_1111);
    wr(8'h08, 32'h0000_0077);
    rd(8'h00, v); chk("R5 hdr0 unchanged", v, 32'hC2B1_A03D);
    rd(8'h0C, v); chk("R5 data unchanged", v, 32'hDEAD_BEEF);
    rd(8'h08, v); chk("R5 hdr2 unchanged", v, 32'h0000_003C);
    finish_cmd(6'h3F, 32'h0);
    rd(8'h70, v); chk("R10 done before accept ignored", v, 0);
    chk("R10 still offering", link_req_valid, 1);
    accept();
    chk("R4 valid drops after accept", link_req_valid, 0);
    rd(8'h00, v); chk("R4 busy while waiting", v[3], 1);
    finish_cmd(6'h00, 32'h0);
    rd(8'h00, v); chk("R6 busy cleared", v, 32'hC2B1_A035);
    rd(8'h70, v); chk("R6 complete only", v, 32'h1000_0000);
    chk("R9 irq set", irq, 1);
    @(negedge clk);
    chk("R5 no second launch", link_req_valid, 0);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    wr(8'h70, 32'h0000_0000);
    rd(8'h70, v); chk("R8 zero write keeps", v, 32'h1000_0000);
    wr(8'h70, 32'h1000_0000);
    rd(8'h70, v); chk("R8 one write clears", v, 0);
    chk("R9 irq clear", irq, 0);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    wr(8'h00, 32'h0000_000C);
    chk("R4 kind periph", link_kind, 4);
    accept();
    finish_cmd(6'b101101, 32'h0);
    rd(8'h70, v); chk("R6 error mapping", v, 32'h1000_0055);
    chk("R9 irq errors", irq, 1);
    wr(8'h70, 32'h0000_0014);
    rd(8'h70, v); chk("R8 partial clear", v, 32'h1000_0041);
    wr(8'h70, 32'hFFFF_FFFF);
    rd(8'h70, v); chk("R8 full clear", v, 0);
    chk("R9 irq low", irq, 0);
  endtask

  task automatic t_config();
    logic [31:0] v;
    wr(8'h04, 32'h1234_5678);
    wr(8'h00, 32'h0007_0009);
    accept();
    finish_cmd(6'h00, 32'hCAFE_F00D);
    rd(8'h04, v); chk("R7 cfg read result", v, 32'hCAFE_F00D);
    wr(8'h04, 32'h55AA_55AA);
    wr(8'h00, 32'h0007_0008);
    chk("R7 cfg write value in hdata", link_hdata[55:24], 32'h55AA_55AA);
    chk("R7 cfg addr bytes", link_hdata[23:0], 24'h000700);
    accept();
    finish_cmd(6'h00, 32'h9999_9999);
    rd(8'h04, v); chk("R7 hdr1 kept for cfg write", v, 32'h55AA_55AA);
    wr(8'h70, 32'hFFFF_FFFF);
  endtask

  task automatic t_set_wins_and_idle_done();
    logic [31:0] v;
    wr(8'h00, 32'h0000_000F);
    accept();
    @(negedge clk);
    host_we = 1'b1; host_addr = 8'h70; host_wdata = 32'h1000_0002;
    link_done = 1'b1; link_err = 6'b000010;
    @(negedge clk);
    host_we = 1'b0; link_done = 1'b0; link_err = '0;
    rd(8'h70, v); chk("R8 set wins over clear", v, 32'h1000_0002);
    wr(8'h70, 32'hFFFF_FFFF);
    finish_cmd(6'h3F, 32'h0);
    rd(8'h70, v); chk("R10 idle done ignored", v, 0);
    chk("R10 irq stays low", irq, 0);
    rd(8'h00, v); chk("R10 stays idle", v[3], 0);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_launch_hold_busy();
        t_w1c();
        t_errors();
        t_config();
        t_set_wins_and_idle_done();
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule